// File: doc/BRIEF.md
# Debug Halt Entry Controller

This controller decides when a processor core parks in its debug halt state and how it leaves it. After the master reset is released, the block counts a fixed number of clock cycles before it lets the core start reset exception processing. A breakpoint request seen early in that count parks the core in halt instead. Once the core is running, a breakpoint request parks it again. The cause is recorded, and it is told apart by whether the core was sitting in its low-power stopped mode at the time.

While the core is parked, the block drives an all-ones status code so a debugger can see that the core is halted. It also notes whether the debugger wrote the program counter. When the debug port sends a resume command, the block raises exactly one of three single-cycle strobes:

- start reset exception processing;
- jump to the loaded program counter;
- continue with the next sequential instruction.

The choice depends on the recorded cause and on the program-counter flag.

Top module: `debug_halt_ctrl`

## Requirements
- R1: While rst_n is low, pst and halt_src read 0 and all three strobes are low.
- R2: A brk_req high at any of the first 8 rising edges after rst_n goes high (edges 0 to 7) moves the block to halt after that edge: pst reads 4'hF and halt_src reads 4'h1.
- R3: With no breakpoint accepted in the window, rst_exc_go is high for one cycle after rising edge 15 (the 16th edge after release). A brk_req during edges 8 to 15 is ignored: pst stays 0 and halt_src stays 0.
- R4: pst reads 4'hF on exactly the cycles the block is halted and 4'h0 on all other cycles.
- R5: A resume sampled while halted from the reset window, with no program-counter write during that halt, pulses rst_exc_go and leaves halt.
- R6: A resume sampled while halted, when pc_written was high on any halted cycle including the resume cycle, pulses jump_pc_go and no other strobe, for any halt cause.
- R7: While running, a brk_req with core_stopped high enters halt with halt_src 4'h2. A later resume without a program-counter write pulses resume_next_go.
- R8: While running, a brk_req with core_stopped low enters halt with halt_src 4'h3. A later resume without a program-counter write pulses resume_next_go.
- R9: The reset-window cause (4'h1) takes priority over the stopped cause (4'h2), which takes priority over the running cause (4'h3). A breakpoint in the reset window with core_stopped high reports 4'h1.
- R10: Each strobe lasts one cycle, and at most one strobe is high at a time. halt_src holds its value until the next halt entry. A brk_req while halted and a resume while not halted have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| brk_req | input | 1 | Breakpoint request |
| core_stopped | input | 1 | Core is in its stopped low-power mode |
| pc_written | input | 1 | Debugger wrote the program counter this cycle |
| resume | input | 1 | Resume command from the debug port |
| pst | output | 4 | Processor status, 4'hF when halted, else 4'h0 |
| halt_src | output | 4 | Cause of the most recent halt (0 none, 1 reset window, 2 stopped, 3 running) |
| rst_exc_go | output | 1 | One-cycle strobe: begin reset exception processing |
| jump_pc_go | output | 1 | One-cycle strobe: start at the loaded program counter |
| resume_next_go | output | 1 | One-cycle strobe: continue with the next instruction |

## Verification
The assertions watch the invariants that hold on every cycle:

- the status code only ever takes its two legal values;
- the strobes are mutually exclusive single-cycle pulses;
- halt is only entered after a breakpoint request;
- the jump and next-instruction strobes only follow a resume taken while halted;
- the recorded cause does not move during a halt.

The exact window edges (edge 7 accepted, edges 8 to 15 ignored), the 16-edge release timing, the priority of causes and the mapping from cause and program-counter flag to strobe depend on history. The bench's scenarios show these by comparing against expected values, cycle by cycle.

// File: rtl/debug_halt_ctrl.sv
module debug_halt_ctrl #(
  parameter int WAIT_CYCLES = 16,
  parameter int BRK_WINDOW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_req,
  input  logic       core_stopped,
  input  logic       pc_written,
  input  logic       resume,
  output logic [3:0] pst,
  output logic [3:0] halt_src,
  output logic       rst_exc_go,
  output logic       jump_pc_go,
  output logic       resume_next_go
);

  localparam int CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_WIN  = CNT_W'(BRK_WINDOW);
  localparam logic [3:0] SRC_NONE  = 4'h0;
  localparam logic [3:0] SRC_RESET = 4'h1;
  localparam logic [3:0] SRC_STOP  = 4'h2;
  localparam logic [3:0] SRC_RUN   = 4'h3;
  localparam logic [3:0] PST_HALT  = 4'hF;
  localparam logic [3:0] PST_IDLE  = 4'h0;

  typedef enum logic [1:0] {S_WAIT, S_RUN, S_HALT} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       src_q;
  logic             pc_ld;

  wire in_window = cnt < CNT_WIN;
  wire use_pc    = pc_ld | pc_written;

  assign pst      = (st == S_HALT) ? PST_HALT : PST_IDLE;
  assign halt_src = src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_WAIT;
      cnt            <= '0;
      src_q          <= SRC_NONE;
      pc_ld          <= 1'b0;
      rst_exc_go     <= 1'b0;
      jump_pc_go     <= 1'b0;
      resume_next_go <= 1'b0;
    end else begin
      rst_exc_go     <= 1'b0;
      jump_pc_go     <= 1'b0;
      resume_next_go <= 1'b0;
      case (st)
        S_WAIT: begin
          if (brk_req && in_window) begin
            st    <= S_HALT;
            src_q <= SRC_RESET;
            pc_ld <= 1'b0;
          end else if (cnt == CNT_LAST) begin
            st         <= S_RUN;
            rst_exc_go <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (brk_req) begin
            st    <= S_HALT;
            src_q <= core_stopped ? SRC_STOP : SRC_RUN;
            pc_ld <= 1'b0;
          end
        end
        S_HALT: begin
          if (resume) begin
            st    <= S_RUN;
            pc_ld <= 1'b0;
            if (use_pc)                  jump_pc_go     <= 1'b1;
            else if (src_q == SRC_RESET) rst_exc_go     <= 1'b1;
            else                         resume_next_go <= 1'b1;
          end else if (pc_written) begin
            pc_ld <= 1'b1;
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/debug_halt_ctrl_chk.sv
module debug_halt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_req,
  input logic       resume,
  input logic [3:0] pst,
  input logic [3:0] halt_src,
  input logic       rst_exc_go,
  input logic       jump_pc_go,
  input logic       resume_next_go
);

  p_pst_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == 4'h0) || (pst == 4'hF));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_exc_go, jump_pc_go, resume_next_go}));

  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_exc_go |=> !rst_exc_go);

  p_jp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    jump_pc_go |=> !jump_pc_go);

  p_rn_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_next_go |=> !resume_next_go);

  p_halt_needs_brk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pst == 4'hF) |-> $past(brk_req));

  p_jp_after_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_pc_go |-> $past(resume && pst == 4'hF));

  p_rn_after_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_next_go |-> $past(resume && pst == 4'hF));

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == 4'hF && !resume) |=> $stable(halt_src));

  p_src_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == 4'hF) |-> (halt_src >= 4'h1 && halt_src <= 4'h3));

endmodule

bind debug_halt_ctrl debug_halt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .resume(resume),
  .pst(pst), .halt_src(halt_src), .rst_exc_go(rst_exc_go),
  .jump_pc_go(jump_pc_go), .resume_next_go(resume_next_go)
);

// File: tb/debug_halt_ctrl_bench.sv
module debug_halt_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_req = 1'b0, core_stopped = 1'b0, pc_written = 1'b0, resume = 1'b0;
  logic [3:0] pst, halt_src;
  logic rst_exc_go, jump_pc_go, resume_next_go;

  always #2.5 clk = ~clk;

  debug_halt_ctrl u_debug_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .core_stopped(core_stopped),
    .pc_written(pc_written), .resume(resume), .pst(pst), .halt_src(halt_src),
    .rst_exc_go(rst_exc_go), .jump_pc_go(jump_pc_go),
    .resume_next_go(resume_next_go)
  );

  typedef struct {
    logic [3:0] pst;
    logic [3:0] src;
    logic [2:0] strb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic step(input logic r, input logic b, input logic s, input logic p,
                      input logic g, input logic [3:0] ep, input logic [3:0] es,
                      input logic [2:0] estr, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = r; brk_req = b; core_stopped = s; pc_written = p; resume = g;
    e.pst = ep; e.src = es; e.strb = estr; e.tag = tag;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pst !== e.pst || halt_src !== e.src ||
          {rst_exc_go, jump_pc_go, resume_next_go} !== e.strb) begin
        errors++;
        $display("FAIL %s: got pst=%h src=%h strb=%b, expected pst=%h src=%h strb=%b",
                 e.tag, pst, halt_src, {rst_exc_go, jump_pc_go, resume_next_go},
                 e.pst, e.src, e.strb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // strobe bits: {rst_exc_go, jump_pc_go, resume_next_go}
    // A: R1 reset, R2 break at edge 3, R5 resume without pc write
    for (int i = 0; i < 3; i++) step(0,0,0,0,0, 4'h0, 4'h0, 3'b000, "R1 reset");
    for (int i = 0; i < 3; i++) step(1,0,0,0,0, 4'h0, 4'h0, 3'b000, "R2 window idle");
    step(1,1,0,0,0, 4'hF, 4'h1, 3'b000, "R2 break edge 3");
    for (int i = 0; i < 20; i++) step(1,0,0,0,0, 4'hF, 4'h1, 3'b000, "R4 halt held");
    step(1,0,0,0,1, 4'h0, 4'h1, 3'b100, "R5 resume to reset exc");
    step(1,0,0,0,0, 4'h0, 4'h1, 3'b000, "R10 pulse one cycle");
    step(1,0,0,0,1, 4'h0, 4'h1, 3'b000, "R10 resume while running ignored");

    // B: R2 break at edge 7, R6 pc written earlier in halt
    for (int i = 0; i < 2; i++) step(0,0,0,0,0, 4'h0, 4'h0, 3'b000, "R1 reset clears src");
    for (int i = 0; i < 7; i++) step(1,0,0,0,0, 4'h0, 4'h0, 3'b000, "R2 window idle");
    step(1,1,0,0,0, 4'hF, 4'h1, 3'b000, "R2 break edge 7");
    step(1,0,0,1,0, 4'hF, 4'h1, 3'b000, "R6 pc write");
    step(1,0,0,0,0, 4'hF, 4'h1, 3'b000, "R4 halt held");
    step(1,0,0,0,1, 4'h0, 4'h1, 3'b010, "R6 jump to pc");
    step(1,0,0,0,0, 4'h0, 4'h1, 3'b000, "R10 pulse one cycle");

    // C: R3 late break ignored, R7/R8 run-time halts
    for (int i = 0; i < 2; i++) step(0,0,0,0,0, 4'h0, 4'h0, 3'b000, "R1 reset");
    for (int i = 0; i < 8; i++) step(1,0,0,0,0, 4'h0, 4'h0, 3'b000, "R3 wait idle");
    for (int i = 8; i < 15; i++) step(1,1,1,0,0, 4'h0, 4'h0, 3'b000, "R3 late break ignored");
    step(1,1,1,0,0, 4'h0, 4'h0, 3'b100, "R3 reset exc after edge 15");
    step(1,0,0,0,0, 4'h0, 4'h0, 3'b000, "R3 single pulse");
    step(1,1,1,0,0, 4'hF, 4'h2, 3'b000, "R7 break while stopped");
    step(1,0,0,0,0, 4'hF, 4'h2, 3'b000, "R4 halt held");
    step(1,0,0,0,1, 4'h0, 4'h2, 3'b001, "R7 resume next");
    step(1,0,0,0,0, 4'h0, 4'h2, 3'b000, "R10 src held after resume");
    step(1,1,0,0,0, 4'hF, 4'h3, 3'b000, "R8 break while running");
    step(1,1,1,0,0, 4'hF, 4'h3, 3'b000, "R10 break while halted ignored");
    step(1,0,0,1,1, 4'h0, 4'h3, 3'b010, "R6 pc write on resume cycle");
    step(1,1,0,0,0, 4'hF, 4'h3, 3'b000, "R8 break while running again");
    step(1,0,0,0,1, 4'h0, 4'h3, 3'b001, "R8 resume next");
    step(1,0,0,0,0, 4'h0, 4'h3, 3'b000, "R10 pulse one cycle");

    // D: R9 priority of reset window over stopped
    for (int i = 0; i < 2; i++) step(0,0,0,0,0, 4'h0, 4'h0, 3'b000, "R1 reset");
    step(1,1,1,0,0, 4'hF, 4'h1, 3'b000, "R9 reset window wins over stopped");
    step(1,0,1,0,1, 4'h0, 4'h1, 3'b100, "R9 R5 resume to reset exc");
    step(1,0,0,0,0, 4'h0, 4'h1, 3'b000, "R10 pulse one cycle");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule